// File: doc/BRIEF.md
# Sampling ADC Conversion Read Controller

This block runs a 12-bit sampling converter from the host side of the link. The converter starts a conversion when it sees a convert-start pulse, finishes that conversion on its own internal clock, and hands back the result over a serial link. When the host raises `start` while the controller is idle, the controller sends the convert-start pulse. It then lets the worst-case conversion time pass, pulls chip select low and waits for the data pin to leave high impedance. After that it sends a burst of twelve serial clock pulses and shifts in the result, most significant bit first. The finished code appears on `result` with a one-cycle `result_valid` strobe.

Every interval is a cycle count worked out from the system clock period. Each count is rounded up, so every minimum is met. The serial clock runs only during readout and stays low at all other times. After the last serial clock falling edge, a quiet interval must pass before `ready` rises again, so no new trigger can come too early. A `start` that arrives while `ready` is low has no effect.

The state machine has seven states. IDLE has `ready` high. PULSE holds the convert-start pulse. CONVERT waits out the conversion time. CS_SETUP has chip select low before the first clock. CLK_LOW and CLK_HIGH are the two serial clock phases. QUIET is the gap after the read. The transitions are:
- IDLE goes to PULSE on start.
- PULSE goes to CONVERT when its timer expires.
- CONVERT goes to CS_SETUP when its timer expires.
- CS_SETUP goes to CLK_LOW when its timer expires.
- CLK_LOW goes to CLK_HIGH when its timer expires, and the data bit is sampled on that edge.
- CLK_HIGH goes back to CLK_LOW when its timer expires and bits remain.
- CLK_HIGH goes to QUIET when its timer expires after the twelfth bit.
- QUIET goes to IDLE when its timer expires.

Top module: `adc_rd_ctrl`

## Requirements
- R1: In reset and right after it, `ready`=1, `adc_cs_n`=1, `adc_convst`=0, `adc_sclk`=0, `result_valid`=0 and `result`=0.
- R2: When `start`=1 is sampled on a clock edge with `ready`=1, `adc_convst` goes high on that edge. It stays high for ceil(10 ns / period) cycles and `ready` drops on the same edge.
- R3: After `adc_convst` falls, `adc_cs_n` stays high and `adc_sclk` stays low for ceil(650 ns / period) cycles. Then `adc_cs_n` falls.
- R4: After `adc_cs_n` falls, ceil(18 ns / period) cycles pass and then a low serial clock phase begins.
- R5: The read has exactly 12 `adc_sclk` pulses. Each pulse is a low phase followed by a high phase, each ceil(10 ns / period) cycles long. `adc_sclk` is high only while `adc_cs_n` is low.
- R6: `adc_sdi` is sampled on the clock edge that drives `adc_sclk` high. The first sample is result bit 11, the MSB, and the twelfth is bit 0. The code is unsigned straight binary.
- R7: `result_valid` is high for one cycle, starting at the edge that captures bit 0. On that same edge `result` takes the new code and then holds it until the next capture.
- R8: `adc_cs_n` rises on the edge where the last `adc_sclk` pulse falls. `ready` stays low for ceil(50 ns / period) cycles after that edge and then rises.
- R9: A `start` sampled while `ready`=0 has no effect: no extra pulse, and the timing of the read in progress does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Sample request, accepted only while ready |
| ready | output | 1 | High when idle and able to accept a request |
| result | output | 12 | Last captured code, straight binary |
| result_valid | output | 1 | One-cycle strobe when result is updated |
| adc_convst | output | 1 | Convert-start pulse to the converter |
| adc_cs_n | output | 1 | Chip select to the converter, active low |
| adc_sclk | output | 1 | Serial read clock, burst only |
| adc_sdi | input | 1 | Serial data from the converter |

## Verification
Suppose the state register or a phase timer goes wrong. Then the edge on `adc_convst`, `adc_cs_n`, `adc_sclk` or `ready` moves by at least one cycle, and the bench compares these pins to its own timeline every cycle, so the error is caught in the cycle it first appears. A wrong bit counter or wrong shift order changes the number of clock pulses or scrambles `result`. The bench uses codes with varied bit patterns so that this shows at the strobe that ends the read. A `start` that leaks through while busy shows up as an early `adc_convst` pulse on the next edge.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_CONVERT,
        ST_CS_SETUP,
        ST_CLK_LOW,
        ST_CLK_HIGH,
        ST_QUIET
    } rd_state_e;

    // whole cycles covering a minimum time, never fewer than one
    function automatic int cycles_for(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired); // R3

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              last_bit,
    input  logic              sdi,
    output logic [DATA_W-1:0] result,
    output logic              result_valid
);
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] sh_next;

    assign sh_next = {sh_q[DATA_W-2:0], sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q         <= '0;
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= shift_en && last_bit;
            if (shift_en)
                sh_q <= sh_next;
            if (shift_en && last_bit)
                result <= sh_next;
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid); // R7

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(result)); // R7

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DATA_W        = 12,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_PULSE_NS    = 10,
    parameter int T_CONV_NS     = 650,
    parameter int T_CSEN_NS     = 18,
    parameter int T_PHASE_NS    = 10,
    parameter int T_QUIET_NS    = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              ready,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              adc_convst,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    input  logic              adc_sdi
);
    localparam int N_PULSE = cycles_for(T_PULSE_NS, CLK_PERIOD_NS);
    localparam int N_CONV  = cycles_for(T_CONV_NS,  CLK_PERIOD_NS);
    localparam int N_CSEN  = cycles_for(T_CSEN_NS,  CLK_PERIOD_NS);
    localparam int N_PHASE = cycles_for(T_PHASE_NS, CLK_PERIOD_NS);
    localparam int N_QUIET = cycles_for(T_QUIET_NS, CLK_PERIOD_NS);
    localparam int N_MAX   = max2(max2(N_PULSE, N_CONV), max2(max2(N_CSEN, N_PHASE), N_QUIET));
    localparam int CNT_W   = $clog2(N_MAX + 1);
    localparam int BIT_W   = $clog2(DATA_W);

    rd_state_e        state_q, state_d;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic [BIT_W-1:0] bit_q;
    logic             last_bit, sample;

    assign last_bit = (bit_q == BIT_W'(DATA_W - 1));

    adc_rd_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // next state, timer reload and sampling decision
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sample   = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start) begin
                state_d  = ST_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(N_PULSE - 1);
            end
            ST_PULSE: if (tmr_done) begin
                state_d  = ST_CONVERT;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(N_CONV - 1);
            end
            ST_CONVERT: if (tmr_done) begin
                state_d  = ST_CS_SETUP;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(N_CSEN - 1);
            end
            ST_CS_SETUP: if (tmr_done) begin
                state_d  = ST_CLK_LOW;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(N_PHASE - 1);
            end
            ST_CLK_LOW: if (tmr_done) begin
                state_d  = ST_CLK_HIGH;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(N_PHASE - 1);
                sample   = 1'b1;
            end
            ST_CLK_HIGH: if (tmr_done) begin
                tmr_load = 1'b1;
                if (last_bit) begin
                    state_d = ST_QUIET;
                    tmr_val = CNT_W'(N_QUIET - 1);
                end else begin
                    state_d = ST_CLK_LOW;
                    tmr_val = CNT_W'(N_PHASE - 1);
                end
            end
            ST_QUIET: if (tmr_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and bit index
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CS_SETUP)
                bit_q <= '0;
            else if (state_q == ST_CLK_HIGH && tmr_done && !last_bit)
                bit_q <= bit_q + 1'b1;
        end
    end

    // registered pin outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (rst) begin
            ready      <= 1'b1;
            adc_convst <= 1'b0;
            adc_cs_n   <= 1'b1;
            adc_sclk   <= 1'b0;
        end else begin
            ready      <= (state_d == ST_IDLE);
            adc_convst <= (state_d == ST_PULSE);
            adc_cs_n   <= !(state_d inside {ST_CS_SETUP, ST_CLK_LOW, ST_CLK_HIGH});
            adc_sclk   <= (state_d == ST_CLK_HIGH);
        end
    end

    adc_rd_shifter #(.DATA_W(DATA_W)) shf_i (
        .clk          (clk),
        .rst          (rst),
        .shift_en     (sample),
        .last_bit     (last_bit),
        .sdi          (adc_sdi),
        .result       (result),
        .result_valid (result_valid)
    );

    AST_SCLK_IN_CS: assert property (@(posedge clk) disable iff (rst)
        adc_sclk |-> !adc_cs_n); // R5

    AST_CONVST_NO_CS: assert property (@(posedge clk) disable iff (rst)
        adc_convst |-> adc_cs_n && !adc_sclk); // R3

    AST_READY_QUIET_PINS: assert property (@(posedge clk) disable iff (rst)
        ready |-> adc_cs_n && !adc_sclk && !adc_convst); // R8

    AST_PULSE_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_convst) |-> $past(ready)); // R9

    AST_VALID_IN_READ: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> !adc_cs_n && adc_sclk); // R6

endmodule

// File: tb/adc_rd_ctrl_tb.sv
module adc_rd_ctrl_tb_top;
    localparam int CLK_NS = 10;
    localparam int DW     = 12;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int C  = cyc(10);
    localparam int W  = cyc(650);
    localparam int S  = cyc(18);
    localparam int H  = cyc(10);
    localparam int Q  = cyc(50);
    localparam int B  = C + W + S;
    localparam int RD_END = B + 2 * DW * H;
    localparam int END_A  = RD_END + Q;
    localparam int VAL_A  = B + (2 * (DW - 1) + 1) * H;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic ready, result_valid, adc_convst, adc_cs_n, adc_sclk, adc_sdi;
    logic [DW-1:0] result;

    always #(CLK_NS / 2) clk = ~clk;

    adc_rd_ctrl #(.DATA_W(DW), .CLK_PERIOD_NS(CLK_NS)) dut_i (
        .clk, .rst, .start, .ready, .result, .result_valid,
        .adc_convst, .adc_cs_n, .adc_sclk, .adc_sdi
    );

    // converter model: MSB after chip select falls, next bit per falling clock
    logic [DW-1:0] adc_code = '0;
    int bidx = 0;
    always @(negedge adc_cs_n) bidx = 0;
    always @(negedge adc_sclk) bidx = bidx + 1;
    assign adc_sdi = (!adc_cs_n && bidx < DW) ? adc_code[DW-1-bidx] : 1'b0;

    // behavioural timeline model
    bit busy = 0;
    int age = 0;
    logic [DW-1:0] cur_code = '0;
    logic [DW-1:0] exp_res = '0;
    bit armed = 0;

    always @(posedge clk) begin
        if (rst) begin
            busy = 0; age = 0; exp_res = '0;
        end else if (busy) begin
            age = age + 1;
            if (age == VAL_A) exp_res = cur_code;
            if (age == END_A) busy = 0;
        end else if (start) begin
            busy = 1; age = 0; cur_code = adc_code;
        end
        armed = 1;
    end

    int n_cmp = 0, n_bad = 0;

    task automatic chk1(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (armed) begin
            logic e_rdy, e_cnv, e_cs, e_sck, e_val;
            int ph;
            e_rdy = !busy;
            e_cnv = busy && age < C;
            e_cs  = !(busy && age >= C + W && age < RD_END);
            ph    = age - B;
            e_sck = busy && age >= B && age < RD_END && ((ph / H) % 2 == 1);
            e_val = busy && age == VAL_A;
            chk1(rst ? "R1 ready" : "R2/R8/R9 ready", ready, e_rdy);
            chk1(rst ? "R1 convst" : "R2/R9 convst", adc_convst, e_cnv);
            chk1(rst ? "R1 cs_n" : "R3/R4/R8 cs_n", adc_cs_n, e_cs);
            chk1(rst ? "R1 sclk" : "R4/R5 sclk", adc_sclk, e_sck);
            chk1(rst ? "R1 valid" : "R7 valid", result_valid, e_val);
            n_cmp++;
            if (result !== exp_res) begin
                n_bad++;
                $display("FAIL R6/R7 result: got %h expected %h at %0t", result, exp_res, $time);
            end
        end
    end

    task automatic wait_ready();
        do @(negedge clk); while (!ready);
    endtask

    task automatic convert(input logic [DW-1:0] code);
        wait_ready();
        adc_code = code;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);   // R1 checked while in reset
        rst = 1'b0;
        repeat (2) @(negedge clk);   // R1 idle after reset
        convert(12'hFFF);            // R6 all ones
        convert(12'h000);            // R6 all zeros
        convert(12'hA5C);            // R6 MSB-first order
        // R9: requests during conversion, readout and quiet are ignored
        convert(12'h801);
        repeat (20) @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (60) @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (12) @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        // R8: start held high gives back-to-back reads spaced by the quiet gap
        wait_ready();
        adc_code = 12'h001;
        start = 1'b1;
        repeat (3 * (END_A + 1)) @(negedge clk);
        start = 1'b0;
        convert(12'h3C6);
        wait_ready();
        repeat (4) @(negedge clk);
        // R1: reset in the middle of a read
        convert(12'h5A5);
        repeat (B + 5) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        convert(12'h7FE);
        wait_ready();
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule